// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Register Store

This block keeps the memory map of a small serially controlled device: sixteen bytes of user memory and three 8-bit codes that set three variable resistor channels. A serial front end hands it byte writes and reads. The written bytes go into a two-byte page buffer. They reach the behavioral nonvolatile array and the live registers only when a stop-condition pulse closes the transaction and a timed write cycle has run to its end. Each channel drives a 6-bit tap position and a high-impedance enable.

A commit always rewrites a whole even-aligned page. A byte that was not written in the transaction is taken from the array, so it keeps its old value. While the write cycle runs, the block raises `busy`, which the front end uses to refuse new transactions. The block also drops any write or stop it receives during that time. A synchronous reset reloads the live registers from the array, so committed settings survive it. The write time is a parameter counted in clock cycles. Its default covers 20 ms at 200 MHz.

Top module: `nvreg_store`

## Requirements
- R1: After the first reset every user byte reads 00h, every channel code reads 3Fh, each `tap_pos` field is 3Fh and every `tap_hiz` bit is 0.
- R2: User bytes sit at addresses 00h–0Fh and channel codes 0, 1 and 2 at F8h, F9h and FAh. Every other address reads 00h, and a write there is discarded. A transaction that wrote only such addresses starts no commit.
- R3: A written byte is not visible on `rd_data`, `tap_pos` or `tap_hiz` before its commit completes.
- R4: A commit starts only when `stop_pulse` arrives while at least one page byte is pending. `busy` is high from the cycle after the stop for exactly WR_CYCLES cycles.
- R5: A page is the byte pair {2k, 2k+1}. Committing a single written byte leaves the other byte of its page unchanged.
- R6: Two bytes written to the same page in one transaction are both committed by a single commit.
- R7: While `busy` is high, `wr_en` and `stop_pulse` have no effect.
- R8: A channel code above 3Fh sets that channel's `tap_hiz`. A code of 3Fh or below clears it. `tap_pos` carries bits 5:0 of the code, and channel n occupies bits [6n+5:6n].
- R9: Reset reloads the live registers from the nonvolatile array. Committed values survive it, and bytes still pending in the buffer are lost.
- R10: The live outputs take their new values in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls stored contents |
| wr_en | input | 1 | Byte write strobe from the serial front end |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| stop_pulse | input | 1 | One-cycle pulse at the stop condition |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Live contents at `rd_addr`, 00h for unmapped addresses |
| busy | output | 1 | Write cycle in progress |
| tap_pos | output | 18 | Tap positions, 6 bits per channel |
| tap_hiz | output | 3 | High-impedance enable per channel |

## Verification
The bench writes one byte of a page whose sibling already holds data. A store that failed to merge the page would zero or corrupt that sibling. It measures the exact length of `busy` and compares code 3Fh against 40h, which would expose a store that committed early or treated the top code as disconnected. It sends writes and a second stop during the write cycle, which a leaky store would commit. It applies reset with a byte still pending, so a store that kept pending data or failed to recall the array would show a wrong tap or a nonzero byte.

// File: rtl/nvreg_store.sv
module nvreg_store #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int USER_BYTES  = 16,
  parameter int NUM_CH      = 3,
  parameter int CH_BASE     = 'hF8,
  parameter int TAP_W       = 6,
  parameter int CH_DEFAULT  = 'h3F,
  parameter int WR_CYCLES   = 4_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     stop_pulse,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     busy,
  output logic [NUM_CH*TAP_W-1:0]  tap_pos,
  output logic [NUM_CH-1:0]        tap_hiz
);
  localparam int CH_SLOTS = NUM_CH + (NUM_CH % 2);
  localparam int NBYTES   = USER_BYTES + CH_SLOTS;
  localparam int IDX_W    = $clog2(NBYTES);
  localparam int PG_W     = IDX_W - 1;
  localparam int CNT_W    = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0] nv_mem   [NBYTES];
  logic [DATA_W-1:0] live_mem [NBYTES];
  logic [DATA_W-1:0] pbuf     [2];
  logic [DATA_W-1:0] merged   [2];
  logic [1:0]        pmask;
  logic [PG_W-1:0]   pg_idx;
  logic [CNT_W-1:0]  cnt;
  logic              commit;

  function automatic logic [IDX_W:0] map_addr(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai < USER_BYTES)
      return {1'b1, IDX_W'(ai)};
    else if (ai >= CH_BASE && ai < CH_BASE + NUM_CH)
      return {1'b1, IDX_W'(USER_BYTES + ai - CH_BASE)};
    else
      return '0;
  endfunction

  logic [IDX_W:0] wmap, rmap;
  assign wmap = map_addr(wr_addr);
  assign rmap = map_addr(rd_addr);

  logic            w_ok;
  logic [PG_W-1:0] w_pg;
  logic            w_lo;
  assign w_ok = wmap[IDX_W] && wr_en && !busy;
  assign w_pg = wmap[IDX_W-1:1];
  assign w_lo = wmap[0];

  assign commit = busy && (cnt == '0);

  initial begin
    for (int i = 0; i < NBYTES; i++)
      nv_mem[i] = (i >= USER_BYTES && i < USER_BYTES + NUM_CH) ? DATA_W'(CH_DEFAULT) : '0;
  end

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_merge
      assign merged[k] = pmask[k] ? pbuf[k] : nv_mem[{pg_idx, 1'(k)}];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (commit) begin
      nv_mem[{pg_idx, 1'b0}] <= merged[0];
      nv_mem[{pg_idx, 1'b1}] <= merged[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) live_mem[i] <= nv_mem[i];
    end else if (commit) begin
      live_mem[{pg_idx, 1'b0}] <= merged[0];
      live_mem[{pg_idx, 1'b1}] <= merged[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask  <= '0;
      pg_idx <= '0;
      pbuf[0] <= '0;
      pbuf[1] <= '0;
    end else if (commit) begin
      pmask <= '0;
    end else if (w_ok) begin
      pg_idx     <= w_pg;
      pbuf[w_lo] <= wr_data;
      if (pmask != '0 && w_pg != pg_idx)
        pmask <= w_lo ? 2'b10 : 2'b01;
      else
        pmask[w_lo] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (stop_pulse && pmask != '0) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WR_CYCLES - 1);
    end
  end

  assign rd_data = rmap[IDX_W] ? live_mem[rmap[IDX_W-1:0]] : '0;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assign tap_pos[c*TAP_W +: TAP_W] = live_mem[USER_BYTES + c][TAP_W-1:0];
      assign tap_hiz[c]                = |live_mem[USER_BYTES + c][DATA_W-1:TAP_W];
    end
  endgenerate
endmodule

// File: rtl/nvreg_store_chk.sv
module nvreg_store_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int USER_BYTES = 16,
  parameter int NUM_CH    = 3,
  parameter int CH_BASE   = 'hF8,
  parameter int TAP_W     = 6,
  parameter int WR_CYCLES = 4_000_000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stop_pulse,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [DATA_W-1:0]       rd_data,
  input logic                    busy,
  input logic [NUM_CH*TAP_W-1:0] tap_pos,
  input logic [NUM_CH-1:0]       tap_hiz
);
  int busy_len;
  logic rd_unmapped;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assign rd_unmapped = (int'(rd_addr) >= USER_BYTES) &&
                       !(int'(rd_addr) >= CH_BASE && int'(rd_addr) < CH_BASE + NUM_CH);

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WR_CYCLES);

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < WR_CYCLES);

  assert_busy_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$fell(busy)) |-> ($stable(tap_pos) && $stable(tap_hiz)));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> rd_data == '0);
endmodule

bind nvreg_store nvreg_store_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_BYTES(USER_BYTES), .NUM_CH(NUM_CH),
  .CH_BASE(CH_BASE), .TAP_W(TAP_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_pulse(stop_pulse), .rd_addr(rd_addr),
  .rd_data(rd_data), .busy(busy), .tap_pos(tap_pos), .tap_hiz(tap_hiz)
);

// File: tb/nvreg_store_tb.sv
`timescale 1ns/1ps
module nvreg_store_tb;
  localparam int WR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        stop_pulse = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;
  logic [17:0] tap_pos;
  logic [2:0]  tap_hiz;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nvreg_store #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_pulse(stop_pulse), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .tap_pos(tap_pos), .tap_hiz(tap_hiz)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    rd_addr = a; #1; d = int'(rd_data);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  function automatic int tap(input int ch);
    return int'(tap_pos[ch*6 +: 6]);
  endfunction

  task automatic t_defaults();
    int d;
    rd(8'h00, d); chk("R1", "user 00", d, 0);
    rd(8'h0F, d); chk("R1", "user 0F", d, 0);
    rd(8'hFA, d); chk("R1", "ch2 code", d, 'h3F);
    chk("R1", "tap0", tap(0), 'h3F);
    chk("R1", "tap2", tap(2), 'h3F);
    chk("R1", "hiz", int'(tap_hiz), 0);
    chk("R1", "busy", int'(busy), 0);
  endtask

  task automatic t_page_merge();
    int d, n;
    wr(8'h00, 8'hAA); wr(8'h01, 8'h55); stop();
    chk("R6", "busy after stop", int'(busy), 1);
    wait_busy(n);
    chk("R4", "busy length", n, WR);
    rd(8'h00, d); chk("R6", "byte 00", d, 'hAA);
    rd(8'h01, d); chk("R6", "byte 01", d, 'h55);
    wr(8'h01, 8'h77);
    rd(8'h01, d); chk("R3", "01 before stop", d, 'h55);
    stop(); wait_busy(n);
    rd(8'h00, d); chk("R5", "sibling 00 kept", d, 'hAA);
    rd(8'h01, d); chk("R5", "byte 01 new", d, 'h77);
  endtask

  task automatic t_channels();
    int d, n;
    wr(8'hF8, 8'h12); wr(8'hF9, 8'h40); stop();
    repeat (2) @(negedge clk);
    chk("R3", "tap0 during busy", tap(0), 'h3F);
    chk("R3", "hiz during busy", int'(tap_hiz), 0);
    while (busy && n < 1000) begin
      @(posedge clk); #1; n++;
    end
    chk("R10", "tap0 as busy falls", tap(0), 'h12);
    @(negedge clk);
    chk("R8", "tap0", tap(0), 'h12);
    chk("R8", "hiz0 at 12h", int'(tap_hiz[0]), 0);
    chk("R8", "tap1 low bits of 40h", tap(1), 0);
    chk("R8", "hiz1 at 40h", int'(tap_hiz[1]), 1);
    wr(8'hFA, 8'hFF); wr(8'hFB, 8'h11); stop(); wait_busy(n);
    chk("R8", "hiz2 at FFh", int'(tap_hiz[2]), 1);
    chk("R8", "tap2 at FFh", tap(2), 'h3F);
    rd(8'hFB, d); chk("R2", "reserved FB", d, 0);
    wr(8'hFA, 8'h3F); stop(); wait_busy(n);
    chk("R8", "hiz2 at 3Fh", int'(tap_hiz[2]), 0);
  endtask

  task automatic t_reserved();
    int d;
    wr(8'h20, 8'h99); wr(8'hFB, 8'h42); stop();
    chk("R2", "no commit for reserved", int'(busy), 0);
    rd(8'h20, d); chk("R2", "reserved 20", d, 0);
  endtask

  task automatic t_no_stop();
    int d, n;
    wr(8'h02, 8'h31); wr(8'h03, 8'h32);
    repeat (20) @(negedge clk);
    chk("R4", "no busy without stop", int'(busy), 0);
    rd(8'h02, d); chk("R3", "02 uncommitted", d, 0);
    stop(); wait_busy(n);
    rd(8'h02, d); chk("R6", "byte 02", d, 'h31);
    rd(8'h03, d); chk("R6", "byte 03", d, 'h32);
  endtask

  task automatic t_busy_ignore();
    int d, n;
    wr(8'h04, 8'h11); stop();
    wr(8'h05, 8'h22); stop();
    wait_busy(n);
    rd(8'h05, d); chk("R7", "write during busy dropped", d, 0);
    rd(8'h04, d); chk("R7", "byte 04", d, 'h11);
    repeat (3) @(negedge clk);
    chk("R7", "stop during busy dropped", int'(busy), 0);
  endtask

  task automatic t_recall();
    int d, n;
    wr(8'hF9, 8'h2A); stop(); wait_busy(n);
    wr(8'h06, 8'hEE);
    do_reset();
    @(negedge clk);
    chk("R9", "tap1 recalled", tap(1), 'h2A);
    chk("R9", "tap0 recalled", tap(0), 'h12);
    rd(8'h00, d); chk("R9", "user 00 recalled", d, 'hAA);
    rd(8'h06, d); chk("R9", "pending 06 lost", d, 0);
    stop();
    chk("R9", "no commit after reset", int'(busy), 0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        @(negedge clk);
        t_defaults();
        t_page_merge();
        t_channels();
        t_reserved();
        t_no_stop();
        t_busy_ignore();
        t_recall();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule